// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a watchdog for an always-on clock domain. A 32-bit counter advances by one on every clock while the watchdog is enabled and an external run-gate input is high. Dropping the run-gate, for example while the system is being debugged or after it has been put into a halted fault state, freezes the count where it is; the count is not cleared. Software keeps the system alive by writing zero to the count (a "pet") before either of two programmable thresholds is reached.

The lower threshold, called the bark threshold, raises a sticky interrupt. The interrupt is cleared by writing a one to the interrupt clear register. The higher threshold, called the bite threshold, raises a reset request that stays high until the count is written or the watchdog is disabled. A write-once unlock bit guards the enable and both thresholds. Once software clears it, only a reset reopens them. Writes to the count stay allowed in that state, so petting keeps working.

Software reaches the block through a single-cycle register write port with a 3-bit register select. Select 0 is control (bit 0 is the enable), 1 is the bark threshold, 2 is the bite threshold, 3 is the count, 4 is the unlock bit and 5 is the interrupt clear.

Top module: `wdog_guard`

## Requirements
- R1: While enabled (control bit 0 is 1) and `run_en_i` is high, `count_o` rises by exactly one per clock. It saturates at 2^32-1 and does not wrap.
- R2: While `run_en_i` is low, `count_o` holds its value unless the count register is written.
- R3: A write with select 3 loads `wr_data_i` into the count on that clock edge, and this takes precedence over the increment. A pet is a write of zero. Count writes are accepted while configuration is locked.
- R4: After reset the watchdog is disabled, the count is 0, both thresholds are all ones, `cfg_open_o` is 1, and `bark_irq_o` and `bite_req_o` are 0.
- R5: A write with select 4 and data bit 0 equal to 0 drives `cfg_open_o` low. A later write with bit 0 equal to 1 does not raise it again; only reset does.
- R6: While `cfg_open_o` is low, writes with select 0, 1 or 2 leave the enable and both thresholds unchanged.
- R7: While enabled, `bark_irq_o` rises on the clock edge after the one on which `count_o` first reaches or passes the bark threshold (select 1). It then stays high.
- R8: A write with select 5 and data bit 0 equal to 1 clears `bark_irq_o` on that edge. If the count is still at or above the bark threshold, the interrupt rises again on the following edge. A write with select 5 and data bit 0 equal to 0 has no effect.
- R9: While enabled, `bite_req_o` rises on the clock edge after the one on which `count_o` reaches or passes the bite threshold (select 2). It stays high, even while the run-gate is low, until the count is written.
- R10: Once the enable has been written to 0, `bark_irq_o` and `bite_req_o` are low from the next clock edge on, and the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_en_i | input | 1 | Run-gate; counting pauses while low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 3 | Register select (0 ctrl, 1 bark, 2 bite, 3 count, 4 unlock, 5 irq clear) |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current watchdog count |
| bark_irq_o | output | 1 | Bark interrupt |
| bite_req_o | output | 1 | Reset request |
| cfg_open_o | output | 1 | 1 while configuration writes are allowed |

## Verification
The bench samples the cycle on which the count equals each threshold and the cycle after it. A comparison that is off by one, or an event flag with an extra register stage, therefore shows up as a one-cycle shift. Clearing the interrupt while the count is still above the bark threshold must give one low cycle and then a reassertion. A design that let the set win over the clear would never show the low cycle, and one that forgot the level would stay low. After the unlock bit is cleared, the bench tries to disable the watchdog and to lower both thresholds. A weak lock would then show the count stopping or an early interrupt. It also writes a one back to the unlock bit and checks the lock stays shut. The count is driven to the top of its range to catch wraparound, and the run-gate is dropped while a reset request is pending to catch a design that clears the request on pause.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [2:0] {
    WS_CTRL  = 3'd0,
    WS_BARK  = 3'd1,
    WS_BITE  = 3'd2,
    WS_COUNT = 3'd3,
    WS_LOCK  = 3'd4,
    WS_INTR  = 3'd5
  } wsel_e;
endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  wsel_e            wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             enable_o,
  output logic [CNT_W-1:0] bark_thr_o,
  output logic [CNT_W-1:0] bite_thr_o,
  output logic             cfg_open_o
);
  localparam logic [CNT_W-1:0] THR_RST = {CNT_W{1'b1}};

  logic cfg_wr;
  logic lock_wr;

  assign cfg_wr  = wr_en_i && cfg_open_o;
  assign lock_wr = wr_en_i && (wr_sel_i == WS_LOCK) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o   <= 1'b0;
      bark_thr_o <= THR_RST;
      bite_thr_o <= THR_RST;
      cfg_open_o <= 1'b1;
    end else begin
      if (cfg_wr && wr_sel_i == WS_CTRL) enable_o   <= wr_data_i[0];
      if (cfg_wr && wr_sel_i == WS_BARK) bark_thr_o <= wr_data_i;
      if (cfg_wr && wr_sel_i == WS_BITE) bite_thr_o <= wr_data_i;
      if (lock_wr)                       cfg_open_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W    = 32,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump_sat(input logic [CNT_W-1:0] c);
    return (c == CNT_TOP) ? c : c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] bump_wrap(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] inc_val;

  generate
    if (SATURATE) begin : g_sat
      assign inc_val = bump_sat(count_o);
    end else begin : g_wrap
      assign inc_val = bump_wrap(count_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (tick_i) count_o <= inc_val;
  end
endmodule

// File: rtl/wdg_events.sv
module wdg_events #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] bark_thr_i,
  input  logic [CNT_W-1:0] bite_thr_i,
  input  logic             intr_clr_i,
  input  logic             pet_i,
  output logic             bark_hit_o,
  output logic             bite_hit_o,
  output logic             bark_irq_o,
  output logic             bite_req_o
);
  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] thr);
    return c >= thr;
  endfunction

  logic bark_q, bite_q;

  assign bark_hit_o = enable_i && reached(count_i, bark_thr_i);
  assign bite_hit_o = enable_i && reached(count_i, bite_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bark_q <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      if (!enable_i || intr_clr_i) bark_q <= 1'b0;
      else if (bark_hit_o)         bark_q <= 1'b1;
      if (!enable_i || pet_i)      bite_q <= 1'b0;
      else if (bite_hit_o)         bite_q <= 1'b1;
    end
  end

  assign bark_irq_o = bark_q && enable_i;
  assign bite_req_o = bite_q && enable_i;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             bark_irq_o,
  output logic             bite_req_o,
  output logic             cfg_open_o
);
  wsel_e            sel_w;
  logic             enable_w;
  logic [CNT_W-1:0] bark_thr_w;
  logic [CNT_W-1:0] bite_thr_w;
  logic             tick_w;
  logic             pet_w;
  logic             intr_clr_w;
  logic             bark_hit_w;
  logic             bite_hit_w;

  assign sel_w      = wsel_e'(wr_sel_i);
  assign tick_w     = enable_w && run_en_i;
  assign pet_w      = wr_en_i && (sel_w == WS_COUNT);
  assign intr_clr_w = wr_en_i && (sel_w == WS_INTR) && wr_data_i[0];

  wdg_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (sel_w),
    .wr_data_i  (wr_data_i),
    .enable_o   (enable_w),
    .bark_thr_o (bark_thr_w),
    .bite_thr_o (bite_thr_w),
    .cfg_open_o (cfg_open_o)
  );

  wdg_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .load_i     (pet_w),
    .load_val_i (wr_data_i),
    .count_o    (count_o)
  );

  wdg_events #(.CNT_W(CNT_W)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_w),
    .count_i    (count_o),
    .bark_thr_i (bark_thr_w),
    .bite_thr_i (bite_thr_w),
    .intr_clr_i (intr_clr_w),
    .pet_i      (pet_w),
    .bark_hit_o (bark_hit_w),
    .bite_hit_o (bite_hit_w),
    .bark_irq_o (bark_irq_o),
    .bite_req_o (bite_req_o)
  );
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             bark_irq_o,
  input logic             bite_req_o,
  input logic             cfg_open_o,
  input logic             enable_w,
  input logic             tick_w,
  input logic             pet_w,
  input logic             intr_clr_w,
  input logic             bark_hit_w,
  input logic             bite_hit_w
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  a_r1_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !pet_w && count_o != CNT_TOP) |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

  a_r1_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pet_w && count_o == CNT_TOP) |=> count_o == CNT_TOP);

  a_r2_gate_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !pet_w) |=> $stable(count_o));

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pet_w |=> count_o == $past(wr_data_i));

  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |=> !cfg_open_o);

  a_r7_bark_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bark_hit_w && !intr_clr_w) |=> (bark_irq_o || !enable_w));

  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_clr_w |=> !bark_irq_o);

  a_r9_bite_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bite_hit_w && !pet_w) |=> (bite_req_o || !enable_w));

  a_r9_pet_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pet_w |=> !bite_req_o);

  a_r10_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_w |-> (!bark_irq_o && !bite_req_o));
endmodule

bind wdog_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_en_i   (run_en_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .bark_irq_o (bark_irq_o),
  .bite_req_o (bite_req_o),
  .cfg_open_o (cfg_open_o),
  .enable_w   (enable_w),
  .tick_w     (tick_w),
  .pet_w      (pet_w),
  .intr_clr_w (intr_clr_w),
  .bark_hit_w (bark_hit_w),
  .bite_hit_w (bite_hit_w)
);

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
  localparam int W = 32;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = 3'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic         bark, bite, open;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_guard #(.CNT_W(W)) i_wdog_guard (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .count_o(count), .bark_irq_o(bark), .bite_req_o(bite), .cfg_open_o(open)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Disable, pet, program thresholds, clear irq, enable: count is 0 on return.
  task automatic setup(input logic [W-1:0] bark_thr, input logic [W-1:0] bite_thr);
    run_en = 1'b1;
    wr(3'd0, 0);
    wr(3'd3, 0);
    wr(3'd1, bark_thr);
    wr(3'd2, bite_thr);
    wr(3'd5, 1);
    wr(3'd0, 1);
  endtask

  task automatic t_reset;
    chk("R4 count", count, 0);
    chk("R4 bark", W'(bark), 0);
    chk("R4 bite", W'(bite), 0);
    chk("R4 open", W'(open), 1);
    run_en = 1'b1;
    idle(4);
    chk("R4 disabled holds count", count, 0);
  endtask

  task automatic t_count;
    setup(TOP, TOP);
    chk("R1 start", count, 0);
    idle(10);
    chk("R1 ten ticks", count, 10);
  endtask

  task automatic t_gate;
    logic [W-1:0] c;
    setup(TOP, TOP);
    idle(3);
    run_en = 1'b0;
    @(negedge clk);
    c = count;
    idle(5);
    chk("R2 gated hold", count, c);
    run_en = 1'b1;
    idle(3);
    chk("R2 resume", count, c + 3);
  endtask

  task automatic t_pet;
    setup(TOP, TOP);
    idle(7);
    wr(3'd3, 0);
    chk("R3 pet zero", count, 0);
    wr(3'd3, 32'h100);
    chk("R3 load value", count, 32'h100);
  endtask

  task automatic t_bark;
    setup(20, TOP);
    idle(20);
    chk("R7 count at bark thr", count, 20);
    chk("R7 irq not yet", W'(bark), 0);
    @(negedge clk);
    chk("R7 irq rises", W'(bark), 1);
    wr(3'd5, 1);
    chk("R8 cleared", W'(bark), 0);
    @(negedge clk);
    chk("R8 reasserts", W'(bark), 1);
    wr(3'd5, 0);
    chk("R8 zero write ignored", W'(bark), 1);
    wr(3'd3, 0);
    wr(3'd5, 1);
    idle(5);
    chk("R8 stays clear below thr", W'(bark), 0);
  endtask

  task automatic t_bite;
    setup(10, 30);
    idle(30);
    chk("R9 count at bite thr", count, 30);
    chk("R9 not yet", W'(bite), 0);
    @(negedge clk);
    chk("R9 rises", W'(bite), 1);
    run_en = 1'b0;
    idle(3);
    chk("R9 held while gated", W'(bite), 1);
    chk("R2 count held", count, 31);
    wr(3'd3, 0);
    chk("R9 pet clears", W'(bite), 0);
    run_en = 1'b1;
  endtask

  task automatic t_disable;
    logic [W-1:0] c;
    setup(5, 8);
    idle(12);
    chk("R10 pre irq", W'(bark), 1);
    chk("R10 pre bite", W'(bite), 1);
    wr(3'd0, 0);
    chk("R10 irq low", W'(bark), 0);
    chk("R10 bite low", W'(bite), 0);
    c = count;
    idle(5);
    chk("R10 count holds", count, c);
    chk("R10 irq stays low", W'(bark), 0);
  endtask

  task automatic t_saturate;
    setup(TOP, TOP);
    wr(3'd3, TOP - 2);
    chk("R1 near top", count, TOP - 2);
    idle(5);
    chk("R1 saturates", count, TOP);
  endtask

  task automatic t_lock;
    setup(50, TOP);
    wr(3'd4, 1);
    chk("R5 one keeps open", W'(open), 1);
    wr(3'd4, 0);
    chk("R5 locked", W'(open), 0);
    wr(3'd4, 1);
    chk("R5 no reopen", W'(open), 0);
    wr(3'd0, 0);
    wr(3'd1, 5);
    wr(3'd2, 8);
    wr(3'd3, 0);
    chk("R3 pet while locked", count, 0);
    wr(3'd5, 1);
    idle(15);
    chk("R6 enable kept", count, 17);
    chk("R6 bark thr kept", W'(bark), 0);
    chk("R6 bite thr kept", W'(bite), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_gate();
    t_pet();
    t_bark();
    t_bite();
    t_disable();
    t_saturate();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule